// File: doc/BRIEF.md
# Mobile DDR Command and Bank State Tracker

This block watches the command pins of a mobile DDR SDRAM on every rising clock. It turns chip select, the three strobes, CKE, the bank address and the address bus into a command. It keeps a state for the whole device and a separate state for each of the four banks. Any command that does not fit the present state raises an error pulse and leaves everything as it was. The block also holds the mode register, the extended mode register and the internal refresh row counter. It can be placed beside a memory model or a controller as a protocol tracker. It carries no data path, no strobe timing and no storage array.

The device states are ready, power-on, precharge power-down, active power-down, self refresh, deep power-down and auto refresh. Read and write bursts last half the programmed burst length in clock cycles. An auto-precharge runs for a set number of cycles, and so does an auto refresh. Self refresh ends when CKE rises. The reported state shows this at once, without waiting for a clock edge.

Top module: `lpddr_cmd_tracker`

## Requirements
- R1: After synchronous reset the tracker reports these values. `dev_state` is power-on (0). Every bank is idle (0). `mode_reg` is 13'h032, which means latency 3, burst length 4, sequential. `ext_mode_reg` and `refresh_row` are 0, and `cmd_err` is low.
- R2: A command is {ras_n,cas_n,we_n} sampled with cs_n low. The codes are 011 open row, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set, 110 burst stop and 111 no-op. With cs_n high, no command is seen and nothing changes.
- R3: From power-on (0), the only way forward is a precharge with addr[10]=1 and CKE high, which moves to ready (1). Any other command there is illegal.
- R4: Open row is legal only on an idle bank, which then becomes active (1). Read and write need the bank to be active, reading (2) or writing (3). A single-bank precharge closes an idle or active bank to idle. A precharge with addr[10]=1 closes every bank, but only when no bank is bursting or auto-precharging.
- R5: A read or write burst keeps the bank in reading or writing for BL/2 cycles, then the bank returns to active. BL is taken from mode_reg[2:0]: 001 gives 2, 010 gives 4, 011 gives 8.
- R6: A read or write with addr[10]=1 moves the bank to auto-precharging (4) once the burst ends. The bank stays there for PRE_CYC cycles (default 2) and then goes idle.
- R7: A burst stop with CKE high returns every reading bank to active. When no bank is reading, it is illegal.
- R8: An illegal command drives `cmd_err` high in the cycle after the edge that sampled it. It changes no device state, bank state or register. Timers that are already running keep counting.
- R9: A mode set is legal only when the device is ready and all banks are idle. With ba=00 it loads `mode_reg`, provided the burst-length field [2:0] is 001, 010 or 011 and the latency field [6:4] is 010 or 011. Bit 3, the burst type, is stored as given. With ba=10 it loads any value into `ext_mode_reg`. Any other bank code, or a reserved field, makes the command illegal.
- R10: A refresh with CKE high, when all banks are idle, enters auto refresh (6) for RFC_CYC cycles (default 4) and then returns to ready. At entry it adds 1 to `refresh_row`, modulo 8192. Any command issued during auto refresh is illegal.
- R11: CKE low with no command enters power-down. With all banks idle it is precharge power-down (2). With rows open but no bank bursting or auto-precharging it is active power-down (3). CKE low while a bank is bursting or auto-precharging, or CKE low with any command, is illegal. While powered down, commands are ignored. CKE high returns the device to ready.
- R12: A refresh with CKE low, when all banks are idle, enters self refresh (4). Once CKE is high, `dev_state` reads ready straight away, before the next clock edge. The register state follows at that edge.
- R13: A burst stop with CKE low, when all banks are idle, enters deep power-down (5). CKE high then returns the device to power-on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock enable pin |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address |
| addr | input | 13 | Row, column, auto-precharge and op-code bits |
| dev_state | output | 3 | Device state code |
| bank_state | output | 12 | Bank state codes, bank i at bits [3i+2:3i] |
| cmd_err | output | 1 | One-cycle illegal command pulse |
| mode_reg | output | 13 | Mode register contents |
| ext_mode_reg | output | 13 | Extended mode register contents |
| refresh_row | output | 13 | Internal refresh row counter |

## Verification
The properties assume that every command input is synchronous to the rising clock edge and settles well before it. CKE is the one input allowed to change between edges. The self-refresh property also assumes that, once CKE goes high, it stays high until the next edge. The stimulus changes every input only at the falling edge. CKE is raised mid-cycle during self refresh only to observe the early exit. Each command is followed by enough idle cycles for its burst, precharge or refresh window to finish before a dependent command is issued. The one exception is the illegal-overlap cases, which are timed on purpose to land inside those windows.

// File: rtl/lpddr_trk_pkg.sv
package lpddr_trk_pkg;

    typedef enum logic [2:0] {
        DEV_PWRON = 3'd0,
        DEV_RUN   = 3'd1,
        DEV_PPD   = 3'd2,
        DEV_APD   = 3'd3,
        DEV_SREF  = 3'd4,
        DEV_DPD   = 3'd5,
        DEV_AREF  = 3'd6
    } dev_st_e;

    typedef enum logic [2:0] {
        BK_IDLE = 3'd0,
        BK_ACT  = 3'd1,
        BK_RD   = 3'd2,
        BK_WR   = 3'd3,
        BK_APRE = 3'd4
    } bank_st_e;

    typedef enum logic [3:0] {
        C_DESEL, C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
    } cmd_e;

    typedef enum logic [2:0] {
        BA_NONE, BA_OPEN, BA_READ, BA_WRITE, BA_CLOSE, BA_STOP
    } bank_act_e;

    localparam logic [12:0] MR_RESET = 13'h032;

    function automatic cmd_e decode_cmd(input logic cs_n, input logic [2:0] rcw);
        if (cs_n) return C_DESEL;
        case (rcw)
            3'b011:  return C_ACT;
            3'b101:  return C_RD;
            3'b100:  return C_WR;
            3'b010:  return C_PRE;
            3'b001:  return C_REF;
            3'b000:  return C_MRS;
            3'b110:  return C_BST;
            default: return C_NOP;
        endcase
    endfunction

    function automatic logic mr_legal(input logic [2:0] bl, input logic [2:0] cl);
        return (bl == 3'd1 || bl == 3'd2 || bl == 3'd3) && (cl == 3'd2 || cl == 3'd3);
    endfunction

    function automatic logic [2:0] burst_beats(input logic [2:0] bl);
        case (bl)
            3'd1:    return 3'd1;
            3'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/lpddr_cmd_decode.sv
module lpddr_cmd_decode
    import lpddr_trk_pkg::*;
(
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);
    assign cmd = decode_cmd(cs_n, {ras_n, cas_n, we_n});
endmodule

// File: rtl/lpddr_bank_fsm.sv
module lpddr_bank_fsm
    import lpddr_trk_pkg::*;
#(
    parameter int PRE_CYC = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  bank_act_e act,
    input  logic      ap_in,
    input  logic [2:0] beats,
    output bank_st_e  state
);
    localparam int CNT_W = $clog2(PRE_CYC + 4) + 1;

    logic [CNT_W-1:0] cnt;
    logic             ap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= BK_IDLE;
            cnt   <= '0;
            ap_q  <= 1'b0;
        end else begin
            case (act)
                BA_OPEN:  state <= BK_ACT;
                BA_CLOSE: state <= BK_IDLE;
                BA_STOP:  state <= BK_ACT;
                BA_READ, BA_WRITE: begin
                    state <= (act == BA_READ) ? BK_RD : BK_WR;
                    cnt   <= CNT_W'(beats - 3'd1);
                    ap_q  <= ap_in;
                end
                default: begin
                    if (state == BK_RD || state == BK_WR) begin
                        if (cnt == '0) begin
                            if (ap_q) begin
                                state <= BK_APRE;
                                cnt   <= CNT_W'(PRE_CYC - 1);
                            end else begin
                                state <= BK_ACT;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end else if (state == BK_APRE) begin
                        if (cnt == '0) state <= BK_IDLE;
                        else           cnt   <= cnt - 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/lpddr_dev_ctrl.sv
module lpddr_dev_ctrl
    import lpddr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int AP_BIT    = 10,
    parameter int RFC_CYC   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cke,
    input  cmd_e                         cmd,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]             addr,
    input  bank_st_e [NUM_BANKS-1:0]     bank_st,
    output bank_act_e [NUM_BANKS-1:0]    bank_act,
    output dev_st_e                      dev_q,
    output logic                         err_q,
    output logic [ROW_W-1:0]             mr_q,
    output logic [ROW_W-1:0]             emr_q,
    output logic [ROW_W-1:0]             ref_row_q
);
    localparam int RC_W = $clog2(RFC_CYC) + 1;

    dev_st_e         dev_d;
    logic            err_d, mr_we, emr_we, aref_go;
    logic            all_idle, any_busy, any_rd, no_cmd;
    logic [RC_W-1:0] rfc_cnt;

    always_comb begin
        all_idle = 1'b1;
        any_busy = 1'b0;
        any_rd   = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_st[i] != BK_IDLE) all_idle = 1'b0;
            if (bank_st[i] inside {BK_RD, BK_WR, BK_APRE}) any_busy = 1'b1;
            if (bank_st[i] == BK_RD) any_rd = 1'b1;
        end
    end

    assign no_cmd = (cmd == C_NOP) || (cmd == C_DESEL);

    always_comb begin
        dev_d   = dev_q;
        err_d   = 1'b0;
        mr_we   = 1'b0;
        emr_we  = 1'b0;
        aref_go = 1'b0;
        for (int i = 0; i < NUM_BANKS; i++) bank_act[i] = BA_NONE;
        case (dev_q)
            DEV_PWRON: if (!no_cmd) begin
                if (cke && cmd == C_PRE && addr[AP_BIT]) dev_d = DEV_RUN;
                else err_d = 1'b1;
            end
            DEV_RUN: if (!cke) begin
                if (no_cmd) begin
                    if (all_idle)      dev_d = DEV_PPD;
                    else if (!any_busy) dev_d = DEV_APD;
                    else               err_d = 1'b1;
                end else if (cmd == C_REF && all_idle) dev_d = DEV_SREF;
                else if (cmd == C_BST && all_idle)     dev_d = DEV_DPD;
                else err_d = 1'b1;
            end else begin
                case (cmd)
                    C_ACT: if (bank_st[ba] == BK_IDLE) bank_act[ba] = BA_OPEN;
                           else err_d = 1'b1;
                    C_RD, C_WR:
                        if (bank_st[ba] inside {BK_ACT, BK_RD, BK_WR})
                            bank_act[ba] = (cmd == C_RD) ? BA_READ : BA_WRITE;
                        else err_d = 1'b1;
                    C_PRE: if (addr[AP_BIT]) begin
                        if (any_busy) err_d = 1'b1;
                        else for (int i = 0; i < NUM_BANKS; i++) bank_act[i] = BA_CLOSE;
                    end else if (bank_st[ba] inside {BK_IDLE, BK_ACT}) bank_act[ba] = BA_CLOSE;
                    else err_d = 1'b1;
                    C_REF: if (all_idle) begin
                        dev_d   = DEV_AREF;
                        aref_go = 1'b1;
                    end else err_d = 1'b1;
                    C_MRS: if (!all_idle) err_d = 1'b1;
                    else if (int'(ba) == 0 && mr_legal(addr[2:0], addr[6:4])) mr_we = 1'b1;
                    else if (int'(ba) == 2) emr_we = 1'b1;
                    else err_d = 1'b1;
                    C_BST: if (any_rd) begin
                        for (int i = 0; i < NUM_BANKS; i++)
                            if (bank_st[i] == BK_RD) bank_act[i] = BA_STOP;
                    end else err_d = 1'b1;
                    default: ;
                endcase
            end
            DEV_PPD, DEV_APD, DEV_SREF: if (cke) dev_d = DEV_RUN;
            DEV_DPD: if (cke) dev_d = DEV_PWRON;
            DEV_AREF: begin
                if (!no_cmd) err_d = 1'b1;
                if (rfc_cnt == '0) dev_d = DEV_RUN;
            end
            default: dev_d = DEV_PWRON;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_q     <= DEV_PWRON;
            err_q     <= 1'b0;
            mr_q      <= ROW_W'(MR_RESET);
            emr_q     <= '0;
            ref_row_q <= '0;
            rfc_cnt   <= '0;
        end else begin
            dev_q <= dev_d;
            err_q <= err_d;
            if (mr_we)  mr_q  <= addr;
            if (emr_we) emr_q <= addr;
            if (aref_go) begin
                ref_row_q <= ref_row_q + 1'b1;
                rfc_cnt   <= RC_W'(RFC_CYC - 1);
            end else if (dev_q == DEV_AREF && rfc_cnt != '0) begin
                rfc_cnt <= rfc_cnt - 1'b1;
            end
        end
    end
endmodule

// File: rtl/lpddr_cmd_tracker.sv
module lpddr_cmd_tracker
    import lpddr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int AP_BIT    = 10,
    parameter int PRE_CYC   = 2,
    parameter int RFC_CYC   = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         cke,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ROW_W-1:0]             addr,
    output logic [2:0]                   dev_state,
    output logic [3*NUM_BANKS-1:0]       bank_state,
    output logic                         cmd_err,
    output logic [ROW_W-1:0]             mode_reg,
    output logic [ROW_W-1:0]             ext_mode_reg,
    output logic [ROW_W-1:0]             refresh_row
);
    cmd_e                      cmd;
    dev_st_e                   dev_q;
    bank_st_e  [NUM_BANKS-1:0] bank_st;
    bank_act_e [NUM_BANKS-1:0] bank_act;
    logic [2:0]                beats;

    lpddr_cmd_decode dec_i (
        .cs_n (cs_n),
        .ras_n(ras_n),
        .cas_n(cas_n),
        .we_n (we_n),
        .cmd  (cmd)
    );

    lpddr_dev_ctrl #(
        .NUM_BANKS(NUM_BANKS),
        .ROW_W    (ROW_W),
        .AP_BIT   (AP_BIT),
        .RFC_CYC  (RFC_CYC)
    ) dev_i (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .cmd      (cmd),
        .ba       (ba),
        .addr     (addr),
        .bank_st  (bank_st),
        .bank_act (bank_act),
        .dev_q    (dev_q),
        .err_q    (cmd_err),
        .mr_q     (mode_reg),
        .emr_q    (ext_mode_reg),
        .ref_row_q(refresh_row)
    );

    assign beats = burst_beats(mode_reg[2:0]);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        lpddr_bank_fsm #(.PRE_CYC(PRE_CYC)) bank_i (
            .clk  (clk),
            .rst  (rst),
            .act  (bank_act[g]),
            .ap_in(addr[AP_BIT]),
            .beats(beats),
            .state(bank_st[g])
        );
        assign bank_state[3*g +: 3] = bank_st[g];
    end

    // Self refresh exit shows on the output as soon as CKE is high.
    assign dev_state = (dev_q == DEV_SREF && cke) ? DEV_RUN : dev_q;
endmodule

// File: rtl/lpddr_cmd_tracker_chk.sv
module lpddr_cmd_tracker_chk
    import lpddr_trk_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cke,
    input logic                   cs_n,
    input logic [2:0]             dev_state,
    input logic [3*NUM_BANKS-1:0] bank_state,
    input logic                   cmd_err,
    input logic [ROW_W-1:0]       mode_reg,
    input logic [ROW_W-1:0]       ext_mode_reg,
    input logic [ROW_W-1:0]       refresh_row
);
    logic all_idle;
    always_comb begin
        all_idle = 1'b1;
        for (int i = 0; i < NUM_BANKS; i++)
            if (bank_state[3*i +: 3] != BK_IDLE) all_idle = 1'b0;
    end

    a_r2_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        (cs_n && cke && dev_state == DEV_RUN) |=> !cmd_err);

    a_r8_err_no_effect: assert property (@(posedge clk) disable iff (rst)
        cmd_err |-> ($stable(mode_reg) && $stable(ext_mode_reg) && $stable(refresh_row)));

    a_r9_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mr_legal(mode_reg[2:0], mode_reg[6:4]));

    a_r10_row_step: assert property (@(posedge clk) disable iff (rst)
        (refresh_row == $past(refresh_row)) || (refresh_row == $past(refresh_row) + 1'b1));

    a_r11_ppd_all_idle: assert property (@(posedge clk) disable iff (rst)
        (dev_state == DEV_PPD) |-> all_idle);

    a_r12_sref_cke_low: assert property (@(posedge clk) disable iff (rst)
        (dev_state == DEV_SREF) |-> !cke);

    a_r13_dpd_exit: assert property (@(posedge clk) disable iff (rst)
        (dev_state == DEV_DPD) |=> (dev_state == DEV_DPD || dev_state == DEV_PWRON));

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bk
        a_r4_idle_opens_only: assert property (@(posedge clk) disable iff (rst)
            (bank_state[3*g +: 3] == BK_IDLE) |=>
            (bank_state[3*g +: 3] == BK_IDLE || bank_state[3*g +: 3] == BK_ACT));
    end
endmodule

bind lpddr_cmd_tracker lpddr_cmd_tracker_chk #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) chk_i (.*);

// File: tb/lpddr_cmd_tracker_tb.sv
module lpddr_cmd_tracker_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, cke, cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [2:0]  dev_state;
    logic [11:0] bank_state;
    logic        cmd_err;
    logic [12:0] mode_reg, ext_mode_reg, refresh_row;

    lpddr_cmd_tracker dut_i (
        .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .dev_state(dev_state), .bank_state(bank_state),
        .cmd_err(cmd_err), .mode_reg(mode_reg), .ext_mode_reg(ext_mode_reg),
        .refresh_row(refresh_row)
    );

    int    n_chk = 0, n_fail = 0;
    string tag = "R1";

    // reference model
    int          mdev, mref;
    int          mbank[4], mcnt[4];
    bit          map[4];
    logic [12:0] mmr, memr, mrow;
    bit          merr;

    task automatic chk(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("dev_state", int'(dev_state), mdev);
        for (int i = 0; i < 4; i++) chk("bank_state", int'(bank_state[3*i +: 3]), mbank[i]);
        chk("cmd_err", int'(cmd_err), int'(merr));
        chk("mode_reg", int'(mode_reg), int'(mmr));
        chk("ext_mode_reg", int'(ext_mode_reg), int'(memr));
        chk("refresh_row", int'(refresh_row), int'(mrow));
    endtask

    task automatic model_reset();
        mdev = 0; mref = 0; mmr = 13'h032; memr = 0; mrow = 0; merr = 0;
        for (int i = 0; i < 4; i++) begin mbank[i] = 0; mcnt[i] = 0; map[i] = 0; end
    endtask

    task automatic step(bit ck, bit cs, bit [2:0] rcw, int b, logic [12:0] a);
        bit nop = cs || (rcw == 3'b111);
        bit bad = 0, allidle = 1, busy = 0, rd = 0;
        int act[4] = '{0, 0, 0, 0};   // 1 open 2 read 3 write 4 close 5 stop
        int nd = mdev;
        int bl = (mmr[2:0] == 3'd1) ? 1 : (mmr[2:0] == 3'd2) ? 2 : 4;
        for (int i = 0; i < 4; i++) begin
            if (mbank[i] != 0) allidle = 0;
            if (mbank[i] >= 2) busy = 1;
            if (mbank[i] == 2) rd = 1;
        end
        case (mdev)
            0: if (!nop) begin
                if (ck && rcw == 3'b010 && a[10]) nd = 1; else bad = 1;
            end
            1: if (!ck) begin
                if (nop) begin
                    if (allidle) nd = 2; else if (!busy) nd = 3; else bad = 1;
                end else if (rcw == 3'b001 && allidle) nd = 4;
                else if (rcw == 3'b110 && allidle) nd = 5;
                else bad = 1;
            end else if (!nop) begin
                case (rcw)
                    3'b011: if (mbank[b] == 0) act[b] = 1; else bad = 1;
                    3'b101, 3'b100:
                        if (mbank[b] >= 1 && mbank[b] <= 3) act[b] = (rcw == 3'b101) ? 2 : 3;
                        else bad = 1;
                    3'b010: if (a[10]) begin
                        if (busy) bad = 1; else for (int i = 0; i < 4; i++) act[i] = 4;
                    end else if (mbank[b] <= 1) act[b] = 4; else bad = 1;
                    3'b001: if (allidle) begin nd = 6; mref = 3; mrow = mrow + 1; end
                            else bad = 1;
                    3'b000: if (!allidle) bad = 1;
                    else if (b == 0 && a[2:0] >= 1 && a[2:0] <= 3 && a[6:4] >= 2 && a[6:4] <= 3) mmr = a;
                    else if (b == 2) memr = a;
                    else bad = 1;
                    default: if (rd) begin
                        for (int i = 0; i < 4; i++) if (mbank[i] == 2) act[i] = 5;
                    end else bad = 1;
                endcase
            end
            2, 3, 4: if (ck) nd = 1;
            5: if (ck) nd = 0;
            default: begin
                if (!nop) bad = 1;
                if (mref == 0) nd = 1; else mref = mref - 1;
            end
        endcase
        for (int i = 0; i < 4; i++) begin
            case (act[i])
                1, 5: mbank[i] = 1;
                4:    mbank[i] = 0;
                2, 3: begin mbank[i] = act[i]; mcnt[i] = bl - 1; map[i] = a[10]; end
                default:
                    if (mbank[i] == 2 || mbank[i] == 3) begin
                        if (mcnt[i] == 0) begin
                            if (map[i]) begin mbank[i] = 4; mcnt[i] = 1; end
                            else mbank[i] = 1;
                        end else mcnt[i]--;
                    end else if (mbank[i] == 4) begin
                        if (mcnt[i] == 0) mbank[i] = 0; else mcnt[i]--;
                    end
            endcase
        end
        mdev = nd;
        merr = bad;
    endtask

    task automatic cyc(string t, bit ck, bit cs, bit [2:0] rcw, int b, logic [12:0] a);
        @(negedge clk);
        compare();
        tag  = t;
        cke  = ck; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b[1:0]; addr = a;
        step(ck, cs, rcw, b, a);
    endtask

    task automatic idle(string t, int n, bit ck = 1);
        for (int k = 0; k < n; k++) cyc(t, ck, 1, 3'b111, 0, 13'h0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1; cke = 1; cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1; ba = 0; addr = 0;
        repeat (3) @(negedge clk);
        model_reset();
        rst = 0;
        step(1, 1, 3'b111, 0, 13'h0);
        // R1 reset values are checked at the first compare
        cyc("R3", 1, 0, 3'b101, 0, 13'h000);       // read in power-on: illegal
        cyc("R3", 1, 0, 3'b010, 0, 13'h000);       // single precharge: illegal
        cyc("R3", 1, 0, 3'b010, 0, 13'h400);       // precharge all: ready
        cyc("R9", 1, 0, 3'b000, 0, 13'h030);       // reserved burst length
        cyc("R9", 1, 0, 3'b000, 1, 13'h032);       // reserved bank code
        cyc("R9", 1, 0, 3'b000, 0, 13'h02B);       // latency 2, interleaved, BL8
        cyc("R9", 1, 0, 3'b000, 2, 13'h0A5);       // extended register
        cyc("R2", 1, 1, 3'b011, 0, 13'h000);       // deselected open row
        cyc("R2", 1, 1, 3'b000, 0, 13'h031);       // deselected mode set
        cyc("R4", 1, 0, 3'b011, 0, 13'h000);       // open bank 0
        cyc("R4", 1, 0, 3'b101, 2, 13'h000);       // read idle bank: illegal
        cyc("R4", 1, 0, 3'b011, 0, 13'h000);       // reopen: illegal
        cyc("R5", 1, 0, 3'b101, 0, 13'h000);       // BL8 read, 4 cycles
        idle("R5", 5);
        cyc("R6", 1, 0, 3'b101, 0, 13'h400);       // read with auto precharge
        idle("R6", 7);
        cyc("R6", 1, 0, 3'b011, 1, 13'h000);
        cyc("R6", 1, 0, 3'b100, 1, 13'h400);       // write with auto precharge
        idle("R6", 7);
        cyc("R8", 1, 0, 3'b011, 2, 13'h000);
        cyc("R8", 1, 0, 3'b100, 2, 13'h000);
        cyc("R8", 1, 0, 3'b010, 2, 13'h000);       // precharge during write
        cyc("R8", 1, 0, 3'b010, 0, 13'h400);       // precharge all during write
        cyc("R8", 1, 0, 3'b000, 0, 13'h032);       // mode set with open rows
        idle("R8", 4);
        cyc("R7", 1, 0, 3'b101, 2, 13'h000);
        cyc("R7", 1, 0, 3'b110, 0, 13'h000);       // stop the read
        cyc("R7", 1, 0, 3'b110, 0, 13'h000);       // nothing reading: illegal
        cyc("R11", 0, 1, 3'b111, 0, 13'h000);      // active power-down
        cyc("R11", 0, 0, 3'b011, 3, 13'h000);      // ignored while down
        idle("R11", 1, 0);
        cyc("R11", 1, 1, 3'b111, 0, 13'h000);      // exit
        cyc("R11", 1, 0, 3'b101, 2, 13'h000);
        cyc("R11", 0, 1, 3'b111, 0, 13'h000);      // CKE low mid-burst: illegal
        cyc("R11", 0, 0, 3'b011, 3, 13'h000);      // CKE low with command: illegal
        idle("R11", 5);
        cyc("R11", 1, 0, 3'b010, 0, 13'h400);
        cyc("R11", 0, 1, 3'b111, 0, 13'h000);      // precharge power-down
        idle("R11", 2, 0);
        idle("R11", 2);
        cyc("R10", 1, 0, 3'b001, 0, 13'h000);      // auto refresh
        cyc("R10", 1, 0, 3'b011, 0, 13'h000);      // command during refresh
        idle("R10", 4);
        cyc("R10", 1, 0, 3'b001, 0, 13'h000);
        idle("R10", 5);
        cyc("R12", 0, 0, 3'b001, 0, 13'h000);      // self refresh entry
        idle("R12", 3, 0);
        @(negedge clk);
        compare();
        tag = "R12";
        cke = 1; cs_n = 1; {ras_n, cas_n, we_n} = 3'b111;
        #1 chk("early exit dev_state", int'(dev_state), 1);
        step(1, 1, 3'b111, 0, 13'h0);
        idle("R12", 2);
        cyc("R13", 0, 0, 3'b110, 0, 13'h000);      // deep power-down
        idle("R13", 3, 0);
        cyc("R13", 1, 1, 3'b111, 0, 13'h000);      // exit to power-on
        cyc("R13", 1, 0, 3'b011, 0, 13'h000);      // illegal in power-on
        cyc("R13", 1, 0, 3'b010, 0, 13'h400);
        idle("R13", 2);
        @(negedge clk);
        compare();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule